// File: doc/BRIEF.md
# Asystole Alarm Timer

This block guards against a heart that has stopped beating. A periodic conversion tick arrives about 3.5 times per second, and each tick advances a decade counter. Every beat reported by an upstream QRS recogniser clears the counter. While beats keep coming, the count stays low and nothing happens. When beats stop, the count climbs through a set of fixed thresholds. Each threshold starts one more step of the alarm sequence.

At the first threshold the normal reading-update path is disabled. At the next one the measured rate input is forced to zero. At the terminal count the counter freezes, the display is latched at 00, both limit alarms and the beeper turn on, and a recorder-start request is raised if the recorder is in automatic mode. The timing depends only on the tick count, so it does not depend on the rate meter's averaging or on its last reading. The beat input may be asynchronous. It is synchronised, and only its rising edge acts.

Top module: `asystole_watch`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `count` is 0, `update_en` is 1, and `rate_zero`, `disp_freeze`, `alarm_hi`, `alarm_lo`, `beeper` and `rec_start` are 0.
- R2: A clock edge with `conv_tick` high raises `count` by exactly one while `count` is below 9, provided no beat edge is being applied.
- R3: A rising edge on `beat_in` clears `count` to 0 at the third clock edge after `beat_in` is first seen high. Two edges are spent synchronising and one registers the clear.
- R4: When a beat clear and a tick fall on the same clock edge, `count` becomes 0.
- R5: `update_en` is 1 when `count` is below 5 and 0 when `count` is 5 or more.
- R6: `rate_zero` is 1 exactly when `count` is 8 or more.
- R7: At `count` 9 the counter holds, and further ticks leave it at 9 until a beat clear.
- R8: `disp_freeze`, `alarm_hi`, `alarm_lo` and `beeper` are all 1 exactly while `count` is 9, and they clear together when a beat resets the counter.
- R9: `rec_start` is 1 only while the alarm of R8 is active and `rec_mode` equals 2'b01 (automatic). The other codes are 2'b00 off, 2'b10 diagnostic and 2'b11 delayed, and none of them raises it.
- R10: A `beat_in` that stays high clears the counter only once, and ticks then advance the count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_tick | input | 1 | One-cycle conversion tick, synchronous to `clk` |
| beat_in | input | 1 | Beat-detected pulse, may be asynchronous |
| rec_mode | input | 2 | Recorder mode: 00 off, 01 auto, 10 diagnostic, 11 delayed |
| count | output | 4 | Current silence count, 0 to 9 |
| update_en | output | 1 | Normal reading update allowed |
| rate_zero | output | 1 | Forces the measured rate input to zero |
| disp_freeze | output | 1 | Latches the display at 00 |
| alarm_hi | output | 1 | High-limit alarm forced active |
| alarm_lo | output | 1 | Low-limit alarm forced active |
| beeper | output | 1 | Beeper drive |
| rec_start | output | 1 | Recorder start request |

## Verification
The bench targets the cycle where a beat clear and a tick coincide. A design that gives the increment priority would show 1 there instead of 0. It also keeps ticking after the count reaches 9, so a counter that wraps or overruns shows up at once. It holds `beat_in` high for a long stretch: a level-sensitive clear would pin the count at zero. It also walks `rec_mode` through all four codes during an alarm, so a design that misdecodes the mode would request recording in diagnostic or delayed mode. Each threshold is checked on both sides, which catches an off-by-one in where `update_en` drops or where `rate_zero` rises.

// File: rtl/asys_pkg.sv
// Shared constants for the asystole alarm timer.
// Assumes a decade counter; thresholds are ordered UPD_OFF < ZERO < HOLD.
package asys_pkg;
    localparam int unsigned CNT_W       = 4;
    localparam int unsigned UPD_OFF_CNT = 5;
    localparam int unsigned ZERO_CNT    = 8;
    localparam int unsigned HOLD_CNT    = 9;

    typedef enum logic [1:0] {
        REC_OFF   = 2'b00,
        REC_AUTO  = 2'b01,
        REC_DIAG  = 2'b10,
        REC_DELAY = 2'b11
    } rec_mode_e;
endpackage

// File: rtl/asys_beat_edge.sv
// Synchronises the asynchronous beat input and emits a one-cycle pulse on
// its rising edge. Assumes beat pulses last longer than one clock period.
module asys_beat_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_async,
    output logic beat_rise
);
    localparam int unsigned LAST = STAGES;

    logic [LAST:0] chain;

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= beat_async;
    end

    // Remaining stages finish synchronising and keep the prior value for edge detection.
    for (genvar g = 1; g <= LAST; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    // Rising edge of the synchronised beat.
    always_comb beat_rise = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/asys_stage_counter.sv
// Decade silence counter: counts ticks, clears on a beat, and holds at the
// terminal value. A clear wins over a tick on the same edge.
module asys_stage_counter #(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned HOLD_CNT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(HOLD_CNT);

    logic at_top;
    always_comb at_top = (cnt == TOP);

    // Count update with clear priority and a stop at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (clear)           cnt <= '0;
        else if (tick && !at_top) cnt <= cnt + 1'b1;
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && !at_top) |=> (cnt == $past(cnt) + 1'b1));
    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
    assert_hold_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (at_top && !clear) |=> (cnt == TOP));
    assert_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);
endmodule

// File: rtl/asys_stage_decode.sv
// Turns the silence count into staged actions. Each output is a pure
// function of the count (and the recorder mode for the start request).
module asys_stage_decode
    import asys_pkg::*;
#(
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned UPD_OFF_CNT = 5,
    parameter int unsigned ZERO_CNT    = 8,
    parameter int unsigned HOLD_CNT    = 9
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       mode,
    output logic             upd_en,
    output logic             zero_rate,
    output logic             freeze,
    output logic             alm_hi,
    output logic             alm_lo,
    output logic             beep,
    output logic             rec_go
);
    localparam logic [CNT_W-1:0] T_UPD  = CNT_W'(UPD_OFF_CNT);
    localparam logic [CNT_W-1:0] T_ZERO = CNT_W'(ZERO_CNT);
    localparam logic [CNT_W-1:0] T_HOLD = CNT_W'(HOLD_CNT);

    // Threshold decode for each stage of the alarm sequence.
    always_comb begin
        upd_en    = (cnt < T_UPD);
        zero_rate = (cnt >= T_ZERO);
        freeze    = (cnt == T_HOLD);
        alm_hi    = freeze;
        alm_lo    = freeze;
        beep      = freeze;
        rec_go    = freeze && (mode == REC_AUTO);
    end
endmodule

// File: rtl/asystole_watch.sv
// Asystole alarm timer top: beat edge detection, staged silence counter and
// action decode. Assumes conv_tick is a one-cycle pulse synchronous to clk.
module asystole_watch
    import asys_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_tick,
    input  logic             beat_in,
    input  logic [1:0]       rec_mode,
    output logic [CNT_W-1:0] count,
    output logic             update_en,
    output logic             rate_zero,
    output logic             disp_freeze,
    output logic             alarm_hi,
    output logic             alarm_lo,
    output logic             beeper,
    output logic             rec_start
);
    logic beat_clr;

    asys_beat_edge #(.STAGES(2)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_async (beat_in),
        .beat_rise  (beat_clr)
    );

    asys_stage_counter #(.CNT_W(CNT_W), .HOLD_CNT(HOLD_CNT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (conv_tick),
        .clear (beat_clr),
        .cnt   (count)
    );

    asys_stage_decode #(
        .CNT_W(CNT_W), .UPD_OFF_CNT(UPD_OFF_CNT),
        .ZERO_CNT(ZERO_CNT), .HOLD_CNT(HOLD_CNT)
    ) u_dec (
        .cnt       (count),
        .mode      (rec_mode),
        .upd_en    (update_en),
        .zero_rate (rate_zero),
        .freeze    (disp_freeze),
        .alm_hi    (alarm_hi),
        .alm_lo    (alarm_lo),
        .beep      (beeper),
        .rec_go    (rec_start)
    );

    assert_alarm_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_hi) |-> ($past(count) == CNT_W'(HOLD_CNT - 1)));
    assert_alarm_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_freeze) |-> $past(beat_clr));
    assert_update_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rate_zero |-> !update_en);
    assert_rec_only_alarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_start |-> (beeper && rec_mode == REC_AUTO));
endmodule

// File: tb/asystole_watch_tb.sv
`timescale 1ns/100ps
module asystole_watch_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_tick = 1'b0;
    logic       beat_in = 1'b0;
    logic [1:0] rec_mode = 2'b00;
    logic [3:0] count;
    logic update_en, rate_zero, disp_freeze, alarm_hi, alarm_lo, beeper, rec_start;

    always #2 clk = ~clk;

    asystole_watch u_dut (
        .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .beat_in(beat_in),
        .rec_mode(rec_mode), .count(count), .update_en(update_en),
        .rate_zero(rate_zero), .disp_freeze(disp_freeze), .alarm_hi(alarm_hi),
        .alarm_lo(alarm_lo), .beeper(beeper), .rec_start(rec_start)
    );

    typedef struct {
        logic [10:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference state kept from the requirements.
    int m_cnt = 0;
    bit b1 = 0, b2 = 0, b3 = 0;

    function automatic logic [10:0] expect_of(int c, logic [1:0] md);
        logic al;
        al = (c == 9);
        return {4'(c), (c < 5), (c >= 8), al, al, al, al, al && (md == 2'b01)};
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected outputs.
    task automatic step(input bit tk, input bit bt, input logic [1:0] md,
                        input bit rs, input string tag);
        bit rise;
        exp_t e;
        @(negedge clk);
        conv_tick = tk; beat_in = bt; rec_mode = md; rst_n = rs;
        @(posedge clk);
        if (!rs) begin
            m_cnt = 0; b1 = 0; b2 = 0; b3 = 0;
        end else begin
            rise = b2 & ~b3;
            if (rise) m_cnt = 0;
            else if (tk && m_cnt < 9) m_cnt = m_cnt + 1;
            b3 = b2; b2 = b1; b1 = bt;
        end
        #0.5;
        e.val = expect_of(m_cnt, md);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare each queued item once the outputs have settled.
    always @(posedge clk) begin
        exp_t e;
        logic [10:0] act;
        #1;
        while (q.size() > 0) begin
            e = q.pop_front();
            act = {count, update_en, rate_zero, disp_freeze, alarm_hi,
                   alarm_lo, beeper, rec_start};
            total++;
            if (act !== e.val) begin
                bad++;
                $display("FAIL %s: actual=%b expected=%b", e.tag, act, e.val);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step(1, 0, 2'b01, 0, "R1");
        // R2: single ticks count up
        repeat (3) step(1, 0, 2'b00, 1, "R2");
        step(0, 0, 2'b00, 1, "R2");
        // R3: beat pulse clears after synchronisation
        repeat (2) step(0, 1, 2'b00, 1, "R3");
        repeat (3) step(0, 0, 2'b00, 1, "R3");
        // R5, R6, R8: climb through every threshold
        for (int i = 0; i < 4; i++) step(1, 0, 2'b00, 1, "R5");
        step(1, 0, 2'b00, 1, "R5");
        step(0, 0, 2'b00, 1, "R5");
        step(1, 0, 2'b00, 1, "R6");
        step(1, 0, 2'b00, 1, "R6");
        step(1, 0, 2'b00, 1, "R6");
        step(1, 0, 2'b00, 1, "R8");
        // R7: extra ticks hold at the terminal count
        repeat (4) step(1, 0, 2'b00, 1, "R7");
        // R9: recorder request only in automatic mode
        step(0, 0, 2'b01, 1, "R9");
        step(0, 0, 2'b10, 1, "R9");
        step(0, 0, 2'b11, 1, "R9");
        step(1, 0, 2'b01, 1, "R9");
        // R8: beat clears the whole alarm together
        step(0, 1, 2'b01, 1, "R8");
        step(0, 1, 2'b01, 1, "R8");
        repeat (3) step(0, 0, 2'b01, 1, "R8");
        // R4: ticks every cycle across a beat edge; clear wins
        repeat (3) step(1, 0, 2'b00, 1, "R4");
        step(1, 1, 2'b00, 1, "R4");
        repeat (2) step(1, 1, 2'b00, 1, "R4");
        repeat (2) step(1, 0, 2'b00, 1, "R4");
        // R10: a held beat clears once, then ticks advance again
        repeat (12) step(1, 1, 2'b01, 1, "R10");
        repeat (2) step(0, 0, 2'b01, 1, "R10");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule